// File: doc/BRIEF.md
# Step Sequencer Reset Holdoff

This block is the timing front end of a clocked step sequencer. It watches a clock trigger and a reset trigger, both as clean logic levels sampled once per sample-rate tick. It keeps a step index that moves forward on each accepted rising clock edge and returns to step zero on a reset.

A signal path that is a little longer on the clock side can make a clock edge land a few samples after a patch-wide reset. The sequencer would then skip its first step. To prevent this, the block refuses clock edges for a fixed window of one millisecond after every reset edge and after power-up. The window is counted in ticks, and its length comes from the sample-rate parameter.

A mode input selects delayed reset instead. In that mode a reset edge only arms a pending flag, and the next accepted clock edge applies it. A run input masks clock edges, and a length input sets where the index wraps. A one-cycle strobe marks every step taken.

Top module: `step_seq_holdoff`

## Requirements
- R1: In immediate mode (`delayed_mode` = 0), a reset rising edge sampled on a tick sets `step_idx` to 0 with `step_adv` low, one clock after that tick cycle.
- R2: The holdoff length is HOLD_TICKS = SAMPLE_RATE_HZ * HOLDOFF_US / 1000000 ticks, which is 48 at the defaults. In immediate mode, a clock edge sampled k ticks after a reset edge is ignored when k < HOLD_TICKS and accepted when k >= HOLD_TICKS. k = 0 is the reset tick itself.
- R3: While `rst_n` is low, `step_idx` is 0 and `step_adv` is 0. Release of `rst_n` acts as a reset edge at tick 0, so clock edges on the first HOLD_TICKS-1 ticks are ignored.
- R4: The inputs are sampled only on cycles with `tick` high. An edge is a 0 on one tick followed by a 1 on the next. Holding `rst_in` high after its edge has no further effect.
- R5: While `run` is 0, clock edges do not move `step_idx` and do not raise `step_adv`.
- R6: An accepted clock edge increments `step_idx` and pulses `step_adv` for exactly one cycle, one clock after the tick cycle. From the last step, the index wraps to 0.
- R7: The last step is `seq_len`-1 for lengths 1 to 16. A length of 0 acts as 1, and lengths above 16 act as 16. An advance from an index at or beyond the last step goes to 0.
- R8: In delayed mode (`delayed_mode` = 1), a reset edge only arms a pending flag and does not start a holdoff. The next accepted clock edge sets `step_idx` to 0 with `step_adv` high, and the following accepted edge moves to step 1.
- R9: When clock and reset edges fall on the same tick in immediate mode, the reset wins and the clock edge is discarded. In delayed mode, a coincident clock edge applies the reset at once.
- R10: A new reset edge that arrives while the holdoff window is running restarts the window from its full length.
- R11: A tick with `delayed_mode` at 0 discards any pending delayed reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| tick | input | 1 | Sample-rate tick enable |
| clk_in | input | 1 | Sequencer clock trigger level |
| rst_in | input | 1 | Sequencer reset trigger level |
| run | input | 1 | High lets clock edges through |
| delayed_mode | input | 1 | 1 selects the delayed reset mode |
| seq_len | input | 5 | Sequence length, 1 to 16 |
| step_idx | output | 4 | Current step index |
| step_adv | output | 1 | One-cycle strobe on every step taken |

## Verification
Both outputs are registered. A trigger sampled in a tick cycle shows up on `step_idx` and `step_adv` one clock later, and cycles without a tick change nothing except dropping the strobe. The bench advances its reference model in the same cycle that it drives a tick. It then compares both outputs at the next falling edge, every cycle, so a result that comes one cycle early or late fails.

Directed sequences place a clock edge exactly HOLD_TICKS-1 and HOLD_TICKS ticks after a reset edge, and after a restarted reset, to pin down the window edges.

// File: rtl/shs_pkg.sv
package shs_pkg;

    // Action the reset controller hands to the step counter for one tick
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_CLEAR   = 2'd1,   // go to step 0, no strobe
        ACT_RESTART = 2'd2,   // go to step 0 with strobe (delayed reset commit)
        ACT_ADVANCE = 2'd3    // next step with strobe
    } step_act_e;

    typedef struct packed {
        logic pend;
    } ctl_state_t;

endpackage

// File: rtl/shs_edge_det.sv
module shs_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = tick ? lvl : prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = tick & lvl[i] & ~prev_q[i];
    end

endmodule

// File: rtl/shs_holdoff.sv
module shs_holdoff #(
    parameter int HOLD_TICKS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    output logic open
);

    localparam int CNT_W = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = RELOAD;
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    // power-up behaves as a reset edge at tick 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end

    assign open = (cnt_q == '0);

endmodule

// File: rtl/shs_reset_ctl.sv
module shs_reset_ctl
    import shs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rise_clk,
    input  logic      rise_rst,
    input  logic      run,
    input  logic      delayed_mode,
    input  logic      hold_open,
    output logic      load_hold,
    output step_act_e act
);

    ctl_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        st_d      = st_q;
        act       = ACT_NONE;
        load_hold = 1'b0;
        accept    = rise_clk & run & hold_open;
        if (tick) begin
            if (!delayed_mode) begin
                st_d.pend = 1'b0;
                if (rise_rst) begin
                    act       = ACT_CLEAR;   // reset wins over a coincident clock
                    load_hold = 1'b1;
                end else if (accept) begin
                    act = ACT_ADVANCE;
                end
            end else begin
                if (accept && (rise_rst || st_q.pend)) begin
                    act       = ACT_RESTART;
                    st_d.pend = 1'b0;
                end else if (accept) begin
                    act = ACT_ADVANCE;
                end else if (rise_rst) begin
                    st_d.pend = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/shs_step_ctr.sv
module shs_step_ctr
    import shs_pkg::*;
#(
    parameter int MAX_STEPS = 16,
    localparam int STEP_W   = $clog2(MAX_STEPS),
    localparam int LEN_W    = $clog2(MAX_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_act_e         act,
    input  logic [LEN_W-1:0]  seq_len,
    output logic [STEP_W-1:0] step,
    output logic              strobe
);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              strobe;
    } ctr_t;

    ctr_t              ctr_d, ctr_q;
    logic [STEP_W-1:0] last;

    always_comb begin
        if (seq_len == '0)
            last = '0;
        else if (seq_len >= LEN_W'(MAX_STEPS))
            last = STEP_W'(MAX_STEPS - 1);
        else
            last = STEP_W'(seq_len - LEN_W'(1));

        ctr_d        = ctr_q;
        ctr_d.strobe = 1'b0;
        unique case (act)
            ACT_CLEAR:   ctr_d.step = '0;
            ACT_RESTART: begin
                ctr_d.step   = '0;
                ctr_d.strobe = 1'b1;
            end
            ACT_ADVANCE: begin
                ctr_d.step   = (ctr_q.step >= last) ? '0 : ctr_q.step + STEP_W'(1);
                ctr_d.strobe = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign step   = ctr_q.step;
    assign strobe = ctr_q.strobe;

endmodule

// File: rtl/step_seq_holdoff.sv
module step_seq_holdoff
    import shs_pkg::*;
#(
    parameter int SAMPLE_RATE_HZ = 48000,
    parameter int HOLDOFF_US     = 1000,
    parameter int MAX_STEPS      = 16,
    localparam int STEP_W        = $clog2(MAX_STEPS),
    localparam int LEN_W         = $clog2(MAX_STEPS + 1),
    localparam int HOLD_RAW      = SAMPLE_RATE_HZ / 1000 * HOLDOFF_US / 1000,
    localparam int HOLD_TICKS    = (HOLD_RAW < 1) ? 1 : HOLD_RAW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clk_in,
    input  logic              rst_in,
    input  logic              run,
    input  logic              delayed_mode,
    input  logic [LEN_W-1:0]  seq_len,
    output logic [STEP_W-1:0] step_idx,
    output logic              step_adv
);

    logic [1:0] rises;
    logic       rise_clk, rise_rst;
    logic       hold_open, load_hold;
    step_act_e  act;

    shs_edge_det #(.N(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .lvl   ({rst_in, clk_in}),
        .rise  (rises)
    );
    assign rise_clk = rises[0];
    assign rise_rst = rises[1];

    shs_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (load_hold),
        .open  (hold_open)
    );

    shs_reset_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .rise_clk     (rise_clk),
        .rise_rst     (rise_rst),
        .run          (run),
        .delayed_mode (delayed_mode),
        .hold_open    (hold_open),
        .load_hold    (load_hold),
        .act          (act)
    );

    shs_step_ctr #(.MAX_STEPS(MAX_STEPS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .seq_len (seq_len),
        .step    (step_idx),
        .strobe  (step_adv)
    );

endmodule

// File: rtl/shs_checker.sv
module shs_checker #(
    parameter int MAX_STEPS = 16,
    localparam int STEP_W   = $clog2(MAX_STEPS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              delayed_mode,
    input logic              rise_rst,
    input logic              hold_open,
    input logic [STEP_W-1:0] step_idx,
    input logic              step_adv
);

    // R1: immediate-mode reset edge lands on step 0 without a strobe
    a_r1_reset_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_rst && !delayed_mode) |=> (step_idx == '0 && !step_adv));

    // R2: no step while the holdoff window is closed
    a_r2_holdoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_open |=> !step_adv);

    // R5: run low masks clock edges
    a_r5_run_masks: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !step_adv);

    // R6: strobe lasts a single cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        step_adv |=> !step_adv);

    // R6: a step either increments or wraps to zero
    a_r6_step_order: assert property (@(posedge clk) disable iff (!rst_n)
        step_adv |-> (step_idx == '0 || step_idx == $past(step_idx) + STEP_W'(1)));

    // R8: in delayed mode the index never moves without a strobe
    a_r8_no_silent_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (delayed_mode && $past(delayed_mode) && !step_adv) |-> $stable(step_idx));

endmodule

bind step_seq_holdoff shs_checker #(.MAX_STEPS(MAX_STEPS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .delayed_mode (delayed_mode),
    .rise_rst     (rise_rst),
    .hold_open    (hold_open),
    .step_idx     (step_idx),
    .step_adv     (step_adv)
);

// File: tb/step_seq_holdoff_tb.sv
`timescale 1ns/1ps
module step_seq_holdoff_tb;

    localparam int RATE  = 48000;
    localparam int HOLD_US = 1000;
    localparam int H     = RATE / 1000 * HOLD_US / 1000;   // R2: 48 ticks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, clk_in = 1'b0, rst_in = 1'b0;
    logic       run = 1'b1, delayed_mode = 1'b0;
    logic [4:0] seq_len = 5'd16;
    logic [3:0] step_idx;
    logic       step_adv;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit m_ckp = 0, m_rsp = 0, m_pend = 0, m_adv = 0;
    int m_hold = H - 1;
    int m_step = 0;

    always #2.5 clk = ~clk;

    step_seq_holdoff u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clk_in(clk_in), .rst_in(rst_in),
        .run(run), .delayed_mode(delayed_mode), .seq_len(seq_len),
        .step_idx(step_idx), .step_adv(step_adv)
    );

    function automatic int last_of(int len);
        if (len == 0) return 0;          // R7
        if (len > 16) return 15;
        return len - 1;
    endfunction

    function automatic int next_of(int s, int len);
        return (s >= last_of(len)) ? 0 : s + 1;
    endfunction

    task automatic model(input bit t, input bit ck, input bit rs);
        bit rc, rr, acc;
        m_adv = 0;
        if (!t) return;
        rc = ck & ~m_ckp;
        rr = rs & ~m_rsp;
        m_ckp = ck;
        m_rsp = rs;
        acc = rc & run & (m_hold == 0);
        if (!delayed_mode) begin
            m_pend = 0;                                   // R11
            if (rr) begin
                m_step = 0; m_hold = H - 1;               // R1 R9 R10
            end else begin
                if (acc) begin
                    m_step = next_of(m_step, seq_len); m_adv = 1;
                end
                if (m_hold != 0) m_hold--;
            end
        end else begin
            if (acc && (rr || m_pend)) begin              // R8
                m_step = 0; m_adv = 1; m_pend = 0;
            end else if (acc) begin
                m_step = next_of(m_step, seq_len); m_adv = 1;
            end else if (rr) begin
                m_pend = 1;
            end
            if (m_hold != 0) m_hold--;
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (step_idx !== 4'(m_step) || step_adv !== m_adv) begin
            failures++;
            $display("FAIL %s: step_idx=%0d step_adv=%0b expected step_idx=%0d step_adv=%0b",
                     tag, step_idx, step_adv, m_step, m_adv);
        end
    endtask

    task automatic cyc(input bit t, input bit ck, input bit rs, input string tag);
        tick = t; clk_in = ck; rst_in = rs;
        model(t, ck, rs);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic tk(input bit ck, input bit rs, input string tag);
        cyc(1'b1, ck, rs, tag);
        cyc(1'b0, ck, rs, tag);
    endtask

    task automatic pulse(input string tag);
        tk(1'b1, 1'b0, tag);
        tk(1'b0, 1'b0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tk(1'b0, 1'b0, tag);
    endtask

    initial begin
        #(190000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd20240);
        // R3: state held during power-up reset
        repeat (3) @(negedge clk);
        check("R3");
        rst_n = 1'b1;

        // R3: edges during power-up holdoff are ignored, later ones counted
        for (int i = 0; i < 40; i++) pulse("R3");

        // R6: wrap at length 5
        seq_len = 5'd5;
        for (int i = 0; i < 12; i++) pulse("R6");
        // R7: other lengths, including 0 and above 16
        seq_len = 5'd3;
        for (int i = 0; i < 7; i++) pulse("R7");
        seq_len = 5'd0;
        for (int i = 0; i < 3; i++) pulse("R7");
        seq_len = 5'd20;
        for (int i = 0; i < 19; i++) pulse("R7");
        seq_len = 5'd16;

        // R1: reset edge, then R4: reset held high
        tk(1'b0, 1'b1, "R1");
        for (int i = 0; i < 6; i++) tk(1'b0, 1'b1, "R4");
        tk(1'b0, 1'b0, "R4");
        // R2: clock pulses through and past the window
        for (int i = 0; i < 30; i++) pulse("R2");

        // R2: clock at k = H-1 is ignored
        tk(1'b0, 1'b1, "R2");
        idle(H - 2, "R2");
        tk(1'b1, 1'b0, "R2");
        idle(3, "R2");
        // R2: clock at k = H is accepted
        tk(1'b0, 1'b1, "R2");
        idle(H - 1, "R2");
        tk(1'b1, 1'b0, "R2");
        idle(2, "R2");

        // R9: coincident edges in immediate mode
        pulse("R9");
        tk(1'b1, 1'b1, "R9");
        tk(1'b0, 1'b0, "R9");
        idle(H, "R9");
        pulse("R9");

        // R10: second reset during the window restarts it
        tk(1'b0, 1'b1, "R10");
        idle(30, "R10");
        tk(1'b0, 1'b1, "R10");
        idle(H - 2, "R10");
        tk(1'b1, 1'b0, "R10");
        tk(1'b0, 1'b0, "R10");
        tk(1'b1, 1'b0, "R10");
        idle(2, "R10");

        // R5: run low masks edges
        run = 1'b0;
        for (int i = 0; i < 5; i++) pulse("R5");
        run = 1'b1;
        pulse("R5");

        // R8: delayed reset commits on next clock
        delayed_mode = 1'b1;
        for (int i = 0; i < 3; i++) pulse("R8");
        tk(1'b0, 1'b1, "R8");
        idle(5, "R8");
        pulse("R8");
        pulse("R8");
        // R9: coincident edges in delayed mode commit at once
        pulse("R9");
        tk(1'b1, 1'b1, "R9");
        tk(1'b0, 1'b0, "R9");
        pulse("R9");
        // R11: leaving delayed mode drops the pending reset
        tk(1'b0, 1'b1, "R11");
        tk(1'b0, 1'b0, "R11");
        delayed_mode = 1'b0;
        tk(1'b0, 1'b0, "R11");
        delayed_mode = 1'b1;
        pulse("R11");
        pulse("R11");
        delayed_mode = 1'b0;

        // R6 random: mixed stimulus against the model
        for (int i = 0; i < 6000; i++) begin
            bit t, ck, rs;
            t  = ($urandom % 3) == 0;
            ck = (($urandom % 4) == 0) ? ~clk_in : clk_in;
            rs = (($urandom % 60) == 0) ? ~rst_in : rst_in;
            if (($urandom % 50) == 0) run = ~run;
            if (($urandom % 300) == 0) delayed_mode = ~delayed_mode;
            if (($urandom % 200) == 0) seq_len = 5'($urandom % 21);
            cyc(t, ck, rs, "R6 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule